// File: doc/BRIEF.md
# AC-link Input Frame Receiver

This block is the receive half of the controller side of an AC'97-style serial audio link. It runs on the bit clock that the codec supplies. It watches the SYNC line that the controller's own transmitter drives and uses each rising SYNC edge to align itself to the frame. It then turns the serial input data line into the parallel fields of one input frame.

Each frame is a 16-bit tag followed by twelve 20-bit slots. From the tag the block reports the codec-ready flag, one valid flag per slot and the 3-bit codec identifier. Slots 1 and 2 carry the codec's answer to a register read. The block returns that answer as a read/write flag, a 7-bit register index and a 16-bit data word, marked by a one-cycle strobe. Slots 3 and 4 carry one stereo record sample pair. The block delivers it as two 16-bit words with a one-cycle strobe of its own.

Every register in the block is clocked on the falling edge of the bit clock. The reset is asynchronous and active low. Its release is synchronised inside the block and takes effect two falling edges after `rst_n` rises.

Top module: `aclink_rx_frame`

## Requirements
- R1: While reset is applied, and after its release until the first frame, codec_ready, slot_valid, codec_id, both strobes and every data output read 0.
- R2: sync and sd_in are sampled on the falling edge of bit_clk. A falling edge that samples sync at 1, after sync was sampled at 0 on the previous falling edge, marks a frame start. The next 256 falling edges supply the tag (16 bits) and then slots 1 to 12 (20 bits each), each field MSB first. A new SYNC rise at any point restarts alignment.
- R3: codec_ready takes tag bit 15 on the falling edge that samples tag bit 0. It then holds until the next tag completes.
- R4: On that same edge, slot_valid[k] takes tag bit 14-k, which is the valid flag of slot k+1, and codec_id takes tag bits 2:0.
- R5: reg_rd_stb is high for exactly one cycle after the edge that samples the last bit of slot 2, and only if tag bits 15, 14 and 13 are all 1. With it, reg_rd_rw carries slot 1 bit 19, reg_rd_index carries slot 1 bits 18:12, and reg_rd_data carries slot 2 bits 19:4.
- R6: pcm_stb is high for exactly one cycle after the edge that samples the last bit of slot 4, and only if tag bits 15, 12 and 11 are all 1. With it, pcm_left carries slot 3 bits 19:4 and pcm_right carries slot 4 bits 19:4. Bits 3:0 of both slots have no effect.
- R7: A frame whose tag bit 15 is 0 raises neither strobe, whatever its slot valid bits say, and it drives codec_ready to 0.
- R8: reg_rd_rw, reg_rd_index and reg_rd_data change only together with reg_rd_stb. pcm_left and pcm_right change only together with pcm_stb.
- R9: Once the last bit of slot 12 has been sampled, values on sd_in have no effect on any output until the next SYNC rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock from the codec; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| sync | input | 1 | Frame sync; its rising edge marks a frame start |
| sd_in | input | 1 | Serial input data from the codec, MSB first |
| codec_ready | output | 1 | Tag bit 15 of the latest frame |
| slot_valid | output | 12 | Bit k is the valid flag of slot k+1 from the latest tag |
| codec_id | output | 3 | Codec identifier from the latest tag |
| reg_rd_stb | output | 1 | One-cycle strobe: register read response available |
| reg_rd_rw | output | 1 | Read/write flag echoed in slot 1 |
| reg_rd_index | output | 7 | Register index echoed in slot 1 |
| reg_rd_data | output | 16 | Register data from slot 2 |
| pcm_stb | output | 1 | One-cycle strobe: record sample pair available |
| pcm_left | output | 16 | Left record sample from slot 3 |
| pcm_right | output | 16 | Right record sample from slot 4 |

## Verification
The assertions assume a bit clock that keeps running and a sync line that stays high through the whole tag phase, so that each frame has exactly one rising edge. They also assume reset is applied before the first frame. The bench changes sync and sd_in only on the rising edge of bit_clk, half a period away from the falling edge that samples them. It holds sync high for the 16 tag bits, lowers it with the first slot bit, and starts a restart frame only during the slot phase, after sync has been low for at least one sample. Between frames it drives long runs of ones and mixed patterns on sd_in while sync stays low, so that the trailing bits of R9 are actually exercised.

// File: rtl/aclink_rx_pkg.sv
package aclink_rx_pkg;

  // Default geometry of one input frame on the link
  localparam int unsigned DEF_TAG_W   = 16;
  localparam int unsigned DEF_SLOT_W  = 20;
  localparam int unsigned DEF_N_SLOTS = 12;
  localparam int unsigned DEF_FIELD_W = 16;
  localparam int unsigned DEF_IDX_W   = 7;
  localparam int unsigned DEF_ID_W    = 3;

  // Position of the framer inside a frame
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TAG  = 2'd1,
    PH_SLOT = 2'd2
  } phase_e;

endpackage

// File: rtl/aclink_rx_framer.sv
module aclink_rx_framer
  import aclink_rx_pkg::*;
#(
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned SLOT_W  = DEF_SLOT_W,
  parameter int unsigned N_SLOTS = DEF_N_SLOTS,
  localparam int unsigned BIT_W  = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W),
  localparam int unsigned SNUM_W = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  output logic              bit_take,
  output logic              tag_end,
  output logic              slot_end,
  output logic [SNUM_W-1:0] slot_num
);

  phase_e              ph_q, ph_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [SNUM_W-1:0]   sn_q, sn_d;
  logic                sync_q;
  logic                sync_rise;

  assign sync_rise = sync & ~sync_q;
  assign slot_num  = sn_q;

  // Next-state: a SYNC rise wins over everything and arms the tag phase
  always_comb begin
    ph_d     = ph_q;
    bit_d    = bit_q;
    sn_d     = sn_q;
    bit_take = 1'b0;
    tag_end  = 1'b0;
    slot_end = 1'b0;
    if (sync_rise) begin
      ph_d  = PH_TAG;
      bit_d = '0;
      sn_d  = '0;
    end else begin
      case (ph_q)
        PH_TAG: begin
          bit_take = 1'b1;
          if (bit_q == BIT_W'(TAG_W - 1)) begin
            tag_end = 1'b1;
            ph_d    = PH_SLOT;
            bit_d   = '0;
            sn_d    = SNUM_W'(1);
          end else begin
            bit_d = bit_q + BIT_W'(1);
          end
        end
        PH_SLOT: begin
          bit_take = 1'b1;
          if (bit_q == BIT_W'(SLOT_W - 1)) begin
            slot_end = 1'b1;
            bit_d    = '0;
            if (sn_q == SNUM_W'(N_SLOTS)) begin
              ph_d = PH_IDLE;
              sn_d = '0;
            end else begin
              sn_d = sn_q + SNUM_W'(1);
            end
          end else begin
            bit_d = bit_q + BIT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      sn_q   <= '0;
      sync_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sn_q   <= sn_d;
      sync_q <= sync;
    end
  end

  // R9
  slot_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (ph_q == PH_SLOT) |-> (sn_q != '0 && sn_q <= SNUM_W'(N_SLOTS)));

  // R2
  bit_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (ph_q == PH_TAG) |-> (bit_q <= BIT_W'(TAG_W - 1)));

endmodule

// File: rtl/aclink_rx_shift.sv
module aclink_rx_shift #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word
);

  logic [W-2:0] sr_q, sr_d;

  // The word seen by the decoder already includes the bit sampled this edge
  assign word = {sr_q, din};

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[W-3:0], din};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/aclink_rx_decode.sv
module aclink_rx_decode
  import aclink_rx_pkg::*;
#(
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned SLOT_W  = DEF_SLOT_W,
  parameter int unsigned N_SLOTS = DEF_N_SLOTS,
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned ID_W    = DEF_ID_W,
  localparam int unsigned SNUM_W = $clog2(N_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tag_end,
  input  logic               slot_end,
  input  logic [SNUM_W-1:0]  slot_num,
  input  logic [SLOT_W-1:0]  word,
  output logic               codec_ready,
  output logic [N_SLOTS-1:0] slot_valid,
  output logic [ID_W-1:0]    codec_id,
  output logic               reg_stb,
  output logic               reg_rw,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [FIELD_W-1:0] reg_data,
  output logic               pcm_stb,
  output logic [FIELD_W-1:0] pcm_left,
  output logic [FIELD_W-1:0] pcm_right
);

  localparam logic [SNUM_W-1:0] SN_ADDR  = SNUM_W'(1);
  localparam logic [SNUM_W-1:0] SN_DATA  = SNUM_W'(2);
  localparam logic [SNUM_W-1:0] SN_LEFT  = SNUM_W'(3);
  localparam logic [SNUM_W-1:0] SN_RIGHT = SNUM_W'(4);

  logic               rdy_q, rdy_d;
  logic [N_SLOTS-1:0] vld_q, vld_d;
  logic [ID_W-1:0]    id_q, id_d;
  logic               rw_h_q, rw_h_d;
  logic [IDX_W-1:0]   idx_h_q, idx_h_d;
  logic [FIELD_W-1:0] left_h_q, left_h_d;
  logic               rstb_q, rstb_d;
  logic               rrw_q, rrw_d;
  logic [IDX_W-1:0]   ridx_q, ridx_d;
  logic [FIELD_W-1:0] rdat_q, rdat_d;
  logic               pstb_q, pstb_d;
  logic [FIELD_W-1:0] pl_q, pl_d;
  logic [FIELD_W-1:0] pr_q, pr_d;

  always_comb begin
    rdy_d    = rdy_q;
    vld_d    = vld_q;
    id_d     = id_q;
    rw_h_d   = rw_h_q;
    idx_h_d  = idx_h_q;
    left_h_d = left_h_q;
    rstb_d   = 1'b0;
    rrw_d    = rrw_q;
    ridx_d   = ridx_q;
    rdat_d   = rdat_q;
    pstb_d   = 1'b0;
    pl_d     = pl_q;
    pr_d     = pr_q;
    if (tag_end) begin
      rdy_d = word[TAG_W-1];
      for (int k = 0; k < N_SLOTS; k++) vld_d[k] = word[TAG_W-2-k];
      id_d = word[ID_W-1:0];
    end
    if (slot_end) begin
      case (slot_num)
        SN_ADDR: begin
          rw_h_d  = word[SLOT_W-1];
          idx_h_d = word[SLOT_W-2 -: IDX_W];
        end
        SN_DATA: begin
          if (rdy_q && vld_q[0] && vld_q[1]) begin
            rstb_d = 1'b1;
            rrw_d  = rw_h_q;
            ridx_d = idx_h_q;
            rdat_d = word[SLOT_W-1 -: FIELD_W];
          end
        end
        SN_LEFT: left_h_d = word[SLOT_W-1 -: FIELD_W];
        SN_RIGHT: begin
          if (rdy_q && vld_q[2] && vld_q[3]) begin
            pstb_d = 1'b1;
            pl_d   = left_h_q;
            pr_d   = word[SLOT_W-1 -: FIELD_W];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      vld_q    <= '0;
      id_q     <= '0;
      rw_h_q   <= 1'b0;
      idx_h_q  <= '0;
      left_h_q <= '0;
      rstb_q   <= 1'b0;
      rrw_q    <= 1'b0;
      ridx_q   <= '0;
      rdat_q   <= '0;
      pstb_q   <= 1'b0;
      pl_q     <= '0;
      pr_q     <= '0;
    end else begin
      rdy_q    <= rdy_d;
      vld_q    <= vld_d;
      id_q     <= id_d;
      rw_h_q   <= rw_h_d;
      idx_h_q  <= idx_h_d;
      left_h_q <= left_h_d;
      rstb_q   <= rstb_d;
      rrw_q    <= rrw_d;
      ridx_q   <= ridx_d;
      rdat_q   <= rdat_d;
      pstb_q   <= pstb_d;
      pl_q     <= pl_d;
      pr_q     <= pr_d;
    end
  end

  assign codec_ready = rdy_q;
  assign slot_valid  = vld_q;
  assign codec_id    = id_q;
  assign reg_stb     = rstb_q;
  assign reg_rw      = rrw_q;
  assign reg_idx     = ridx_q;
  assign reg_data    = rdat_q;
  assign pcm_stb     = pstb_q;
  assign pcm_left    = pl_q;
  assign pcm_right   = pr_q;

  // R5
  rd_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    reg_stb |=> !reg_stb);

  // R5
  rd_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
    reg_stb |-> (codec_ready && slot_valid[0] && slot_valid[1]));

  // R6
  pcm_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    pcm_stb |=> !pcm_stb);

  // R7
  pcm_gate_chk: assert property (@(negedge clk) disable iff (!rst_n)
    pcm_stb |-> (codec_ready && slot_valid[2] && slot_valid[3]));

  // R8
  pcm_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !pcm_stb |-> ($stable(pcm_left) && $stable(pcm_right)));

  // R8
  rd_hold_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !reg_stb |-> ($stable(reg_data) && $stable(reg_idx) && $stable(reg_rw)));

endmodule

// File: rtl/aclink_rx_frame.sv
module aclink_rx_frame
  import aclink_rx_pkg::*;
#(
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned SLOT_W  = DEF_SLOT_W,
  parameter int unsigned N_SLOTS = DEF_N_SLOTS,
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned ID_W    = DEF_ID_W,
  localparam int unsigned SNUM_W = $clog2(N_SLOTS + 1)
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               sync,
  input  logic               sd_in,
  output logic               codec_ready,
  output logic [N_SLOTS-1:0] slot_valid,
  output logic [ID_W-1:0]    codec_id,
  output logic               reg_rd_stb,
  output logic               reg_rd_rw,
  output logic [IDX_W-1:0]   reg_rd_index,
  output logic [FIELD_W-1:0] reg_rd_data,
  output logic               pcm_stb,
  output logic [FIELD_W-1:0] pcm_left,
  output logic [FIELD_W-1:0] pcm_right
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sn;
  logic              bit_take;
  logic              tag_end;
  logic              slot_end;
  logic [SNUM_W-1:0] slot_num;
  logic [SLOT_W-1:0] word;

  // Assert at once, release after two falling edges
  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  aclink_rx_framer #(
    .TAG_W   (TAG_W),
    .SLOT_W  (SLOT_W),
    .N_SLOTS (N_SLOTS)
  ) i_framer (
    .clk      (bit_clk),
    .rst_n    (rst_sn),
    .sync     (sync),
    .bit_take (bit_take),
    .tag_end  (tag_end),
    .slot_end (slot_end),
    .slot_num (slot_num)
  );

  aclink_rx_shift #(
    .W (SLOT_W)
  ) i_shift (
    .clk      (bit_clk),
    .rst_n    (rst_sn),
    .shift_en (bit_take),
    .din      (sd_in),
    .word     (word)
  );

  aclink_rx_decode #(
    .TAG_W   (TAG_W),
    .SLOT_W  (SLOT_W),
    .N_SLOTS (N_SLOTS),
    .FIELD_W (FIELD_W),
    .IDX_W   (IDX_W),
    .ID_W    (ID_W)
  ) i_decode (
    .clk         (bit_clk),
    .rst_n       (rst_sn),
    .tag_end     (tag_end),
    .slot_end    (slot_end),
    .slot_num    (slot_num),
    .word        (word),
    .codec_ready (codec_ready),
    .slot_valid  (slot_valid),
    .codec_id    (codec_id),
    .reg_stb     (reg_rd_stb),
    .reg_rw      (reg_rd_rw),
    .reg_idx     (reg_rd_index),
    .reg_data    (reg_rd_data),
    .pcm_stb     (pcm_stb),
    .pcm_left    (pcm_left),
    .pcm_right   (pcm_right)
  );

endmodule

// File: tb/test_aclink_rx_frame.sv
module test_aclink_rx_frame;

  localparam int FRAME_BITS = 256;

  logic        clk;
  logic        rst_n;
  logic        sync;
  logic        sd_in;
  logic        codec_ready;
  logic [11:0] slot_valid;
  logic [2:0]  codec_id;
  logic        reg_rd_stb;
  logic        reg_rd_rw;
  logic [6:0]  reg_rd_index;
  logic [15:0] reg_rd_data;
  logic        pcm_stb;
  logic [15:0] pcm_left;
  logic [15:0] pcm_right;

  aclink_rx_frame i_aclink_rx_frame (
    .bit_clk      (clk),
    .rst_n        (rst_n),
    .sync         (sync),
    .sd_in        (sd_in),
    .codec_ready  (codec_ready),
    .slot_valid   (slot_valid),
    .codec_id     (codec_id),
    .reg_rd_stb   (reg_rd_stb),
    .reg_rd_rw    (reg_rd_rw),
    .reg_rd_index (reg_rd_index),
    .reg_rd_data  (reg_rd_data),
    .pcm_stb      (pcm_stb),
    .pcm_left     (pcm_left),
    .pcm_right    (pcm_right)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  int vectors;
  int miscompares;
  int n_reg;
  int n_pcm;
  bit chk_en;
  bit done;

  // ---------------- reference model (falling-edge sampling) ----------------
  logic        m_bits [FRAME_BITS];
  int          m_pos;
  logic        m_prev;
  logic        exp_ready;
  logic [11:0] exp_vld;
  logic [2:0]  exp_id;
  logic        exp_rstb;
  logic        exp_rw;
  logic [6:0]  exp_idx;
  logic [15:0] exp_rdat;
  logic        exp_pstb;
  logic [15:0] exp_left;
  logic [15:0] exp_right;

  function automatic logic [19:0] model_slot(input int s);
    logic [19:0] r;
    for (int j = 0; j < 20; j++) r[19-j] = m_bits[16 + 20*(s-1) + j];
    return r;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pos = -1; m_prev = 1'b0;
      exp_ready = 0; exp_vld = 0; exp_id = 0; exp_rstb = 0; exp_rw = 0;
      exp_idx = 0; exp_rdat = 0; exp_pstb = 0; exp_left = 0; exp_right = 0;
    end else begin
      exp_rstb = 1'b0;
      exp_pstb = 1'b0;
      if (sync && !m_prev) begin
        m_pos = 0;
      end else if (m_pos >= 0) begin
        m_bits[m_pos] = sd_in;
        if (m_pos == 15) begin
          logic [15:0] t;
          for (int j = 0; j < 16; j++) t[15-j] = m_bits[j];
          exp_ready = t[15];
          for (int k = 0; k < 12; k++) exp_vld[k] = t[14-k];
          exp_id = t[2:0];
        end
        if (m_pos == 16 + 40 - 1 && exp_ready && exp_vld[0] && exp_vld[1]) begin
          logic [19:0] a;
          logic [19:0] d;
          a = model_slot(1); d = model_slot(2);
          exp_rstb = 1'b1; exp_rw = a[19]; exp_idx = a[18:12]; exp_rdat = d[19:4];
        end
        if (m_pos == 16 + 80 - 1 && exp_ready && exp_vld[2] && exp_vld[3]) begin
          logic [19:0] l;
          logic [19:0] r;
          l = model_slot(3); r = model_slot(4);
          exp_pstb = 1'b1; exp_left = l[19:4]; exp_right = r[19:4];
        end
        m_pos++;
        if (m_pos == FRAME_BITS) m_pos = -1;
      end
      m_prev = sync;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_field(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (reg_rd_stb === 1'b1) n_reg++;
    if (pcm_stb === 1'b1) n_pcm++;
    if (chk_en) begin
      vectors++;
      cmp_field("R3", "codec_ready", 32'(codec_ready), 32'(exp_ready));
      cmp_field("R4", "slot_valid", 32'(slot_valid), 32'(exp_vld));
      cmp_field("R4", "codec_id", 32'(codec_id), 32'(exp_id));
      cmp_field("R5 R7", "reg_rd_stb", 32'(reg_rd_stb), 32'(exp_rstb));
      cmp_field("R5 R8", "reg_rd_rw", 32'(reg_rd_rw), 32'(exp_rw));
      cmp_field("R5 R8", "reg_rd_index", 32'(reg_rd_index), 32'(exp_idx));
      cmp_field("R5 R8", "reg_rd_data", 32'(reg_rd_data), 32'(exp_rdat));
      cmp_field("R6 R7", "pcm_stb", 32'(pcm_stb), 32'(exp_pstb));
      cmp_field("R6 R8", "pcm_left", 32'(pcm_left), 32'(exp_left));
      cmp_field("R6 R8", "pcm_right", 32'(pcm_right), 32'(exp_right));
    end
  end

  // ---------------- stimulus ----------------
  logic [19:0] fr_slot [12];

  function automatic logic [15:0] mk_tag(input logic rdy, input logic [11:0] vld_s1_first,
                                         input logic [2:0] id);
    return {rdy, vld_s1_first, id};
  endfunction

  task automatic fill_slots(input logic [19:0] s1, input logic [19:0] s2,
                            input logic [19:0] s3, input logic [19:0] s4);
    fr_slot[0] = s1; fr_slot[1] = s2; fr_slot[2] = s3; fr_slot[3] = s4;
    for (int s = 4; s < 12; s++) fr_slot[s] = 20'h0F0F0 ^ 20'(s * 20'h1111);
  endtask

  task automatic send_frame(input logic [15:0] tag, input int stop_at);
    @(posedge clk);
    sync = 1'b1; sd_in = 1'b0;
    for (int i = 0; i < stop_at; i++) begin
      @(posedge clk);
      sync = (i < 16);
      if (i < 16) sd_in = tag[15-i];
      else        sd_in = fr_slot[(i-16)/20][19 - ((i-16) % 20)];
    end
  endtask

  task automatic idle(input int n, input logic [7:0] pat);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      sync = 1'b0; sd_in = pat[i % 8];
    end
  endtask

  initial begin
    vectors = 0; miscompares = 0; n_reg = 0; n_pcm = 0;
    chk_en = 1'b0; done = 1'b0;
    sync = 1'b0; sd_in = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    // R1: outputs cleared while reset is held
    chk("R1", "codec_ready in reset", 32'(codec_ready), 32'd0);
    chk("R1", "strobes in reset", 32'({reg_rd_stb, pcm_stb}), 32'd0);
    chk("R1", "data in reset", 32'(pcm_left | pcm_right | reg_rd_data), 32'd0);
    chk("R1", "tag fields in reset", 32'({slot_valid, codec_id}), 32'd0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    idle(6, 8'h00);
    // R1: still cleared after release, before any frame
    chk("R1", "codec_ready after release", 32'(codec_ready), 32'd0);

    // Frame A: all valid, register read + record pair (R2 R5 R6)
    fill_slots({1'b1, 7'h26, 12'h000}, {16'h1234, 4'h0},
               {16'hA5C3, 4'h0}, {16'h5A3C, 4'h0});
    send_frame(mk_tag(1'b1, 12'hFFF, 3'b010), FRAME_BITS);
    idle(8, 8'hFF);
    chk("R2", "pcm_left bit order", 32'(pcm_left), 32'h0000A5C3);
    chk("R6", "pcm_right", 32'(pcm_right), 32'h00005A3C);
    chk("R5", "reg_rd_index", 32'(reg_rd_index), 32'h26);
    chk("R5", "reg_rd_data", 32'(reg_rd_data), 32'h1234);
    chk("R4", "codec_id", 32'(codec_id), 32'd2);
    chk("R5", "reg strobe count", 32'(n_reg), 32'd1);

    // Frame B: slots 1,2,4 valid only -> register read, no PCM (R6)
    fill_slots({1'b0, 7'h7C, 12'hABC}, {16'hBEEF, 4'h9},
               {16'h1111, 4'hF}, {16'h2222, 4'hF});
    send_frame(mk_tag(1'b1, 12'b1101_0000_0000, 3'b001), FRAME_BITS);
    idle(8, 8'hA5);
    chk("R6", "no pcm without slot 3", 32'(n_pcm), 32'd1);
    chk("R5", "second register read", 32'(n_reg), 32'd2);

    // Frame C: frame-valid clear, all slot bits set (R7)
    fill_slots({1'b1, 7'h11, 12'h000}, {16'hDEAD, 4'h0},
               {16'h3333, 4'h0}, {16'h4444, 4'h0});
    send_frame(mk_tag(1'b0, 12'hFFF, 3'b111), FRAME_BITS);
    idle(8, 8'h3C);
    chk("R7", "no strobes on invalid frame", 32'(n_reg + n_pcm), 32'd3);
    chk("R7", "codec_ready cleared", 32'(codec_ready), 32'd0);
    chk("R8", "pcm_left held", 32'(pcm_left), 32'h0000A5C3);

    // Frame D: PCM only, nonzero low nibble ignored (R6)
    fill_slots({1'b1, 7'h01, 12'hFFF}, {16'hCAFE, 4'hF},
               {16'h8001, 4'hF}, {16'h7FFE, 4'hA});
    send_frame(mk_tag(1'b1, 12'b0011_0000_0000, 3'b100), FRAME_BITS);
    idle(40, 8'hFF);
    chk("R6", "pcm_left upper bits", 32'(pcm_left), 32'h00008001);
    chk("R6", "pcm_right upper bits", 32'(pcm_right), 32'h00007FFE);
    chk("R9", "trailing bits ignored", 32'(n_reg + n_pcm), 32'd4);

    // Frame E: slot 1 valid, slot 2 not -> no register read (R5)
    send_frame(mk_tag(1'b1, 12'b1000_0000_0000, 3'b000), FRAME_BITS);
    idle(8, 8'h0F);
    chk("R5", "no read without slot 2", 32'(n_reg), 32'd2);

    // Frame F aborted in slot 2, then restarted frame (R2)
    fill_slots({1'b1, 7'h55, 12'h000}, {16'h0BAD, 4'h0},
               {16'hFFFF, 4'h0}, {16'hFFFF, 4'h0});
    send_frame(mk_tag(1'b1, 12'hFFF, 3'b011), 50);
    fill_slots({1'b0, 7'h2A, 12'h000}, {16'h600D, 4'h0},
               {16'h0F0F, 4'h0}, {16'hF0F0, 4'h0});
    send_frame(mk_tag(1'b1, 12'hFFF, 3'b011), FRAME_BITS);
    idle(8, 8'h00);
    chk("R2", "restart read count", 32'(n_reg), 32'd3);
    chk("R2", "restart read data", 32'(reg_rd_data), 32'h600D);
    chk("R2", "restart pcm_left", 32'(pcm_left), 32'h00000F0F);

    // Mixed frames
    for (int f = 0; f < 5; f++) begin
      fill_slots(20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom));
      send_frame(16'($urandom), FRAME_BITS);
      idle(5 + f, 8'($urandom));
    end
    idle(4, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule